// File: doc/BRIEF.md
# Event-Selecting Performance Counter Unit

This unit keeps three counters for profiling a processor core. The first is a free-running clock-cycle counter, with an optional prescaler that divides by 64. The other two are event counters, each fed by one of many event sources chosen through a 6-bit select code in a shared control register. Event sources come in two kinds:

- **Single-cycle pulses**, such as cache misses, TLB misses and branch outcomes. These are counted on every cycle they are high.
- **Level conditions**, such as stalls and ongoing accesses. For each of these, the select code also chooses how to count: an even code adds one per occurrence, seen as a rising edge of the level; the matching odd code adds one for every cycle the level is high.

Every counter has an overflow flag that is set when it wraps from all-ones to zero, and an interrupt enable. The interrupt output is high while any enabled flag is set.

Software reaches the unit through a single-cycle register port. It has four word addresses, a write strobe and a combinational read-data path. Writing a counter's address loads that counter. Two control bits act as one-shot clear commands and always read back as zero.

Top module: `evt_perf_counters`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: While control bit 0 is 1 and bit 3 is 0, the cycle counter (address 1) increases by one each clock. While bit 0 is 0, it holds its value.
- R3: While control bits 0 and 3 are both 1, the cycle counter advances once every 64 enabled clocks.
- R4: Writing control with bit 2 set clears the cycle counter and its prescaler at that edge. Control bits 1 and 2 always read back as 0.
- R5: Select codes 0x00–0x07 count `ev_pulse[code]`, and codes 0x14–0x19 count `ev_pulse[code-12]`. The counter adds one for each clock the chosen pulse bit is high.
- R6: Select codes 0x08–0x13 use `ev_level[(code-8)/2]`. An even code adds one on each clock where that level is high and was low the clock before. An odd code adds one on each clock where the level is high.
- R7: Select codes 0x1A–0x3F never change the counter.
- R8: Writing control with bit 1 set clears both event counters at that edge.
- R9: A write to address 1, 2 or 3 loads the cycle counter, event counter 0 or event counter 1, and takes priority over counting. An increment that wraps from 0xFFFFFFFF to 0 sets the flag: bit 8 for counter 0, bit 9 for counter 1, bit 10 for the cycle counter.
- R10: Writing 1 to a flag bit (bits 10:8) in a control write clears that flag. Writing 0 leaves it unchanged. A wrap in the same cycle sets the flag anyway.
- R11: `irq` is high exactly when some flag in bits 10:8 is set and the enable at the same position in bits 6:4 is also set.
- R12: Address 0 is control. Bits 17:12 select counter 0 and bits 23:18 select counter 1. Bits 7, 11 and 31:24 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 control, 1 cycle counter, 2 counter 0, 3 counter 1 |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_pulse | input | 14 | Single-cycle event pulses |
| ev_level | input | 6 | Level conditions counted by occurrence or by duration |
| irq | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
Every effect in this unit lands at the rising edge where its cause is sampled. This covers counting, register loads, clear strobes and flag updates. The result can be read on `reg_rdata` and `irq` in the low phase that follows, with no further latency.

The occurrence style compares the level with its value from the previous edge. Because of this, the bench's reference model records the previous level once per edge. The prescaler is modelled as its own counter of enabled cycles.

Inputs change at the falling edge. The model updates at the rising edge. The bench compares read data and `irq` at the next falling edge, one comparison per clock. It walks the read address across all four registers so that every counter is compared at that fixed point.

// File: rtl/evt_perf_counters.sv
module evt_perf_counters #(
  parameter int CW       = 32,
  parameter int PRE_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [13:0] ev_pulse,
  input  logic [5:0]  ev_level,
  output logic        irq
);
  localparam int NCNT = 2;

  logic                     cc_en, cc_pre;
  logic [2:0]               ie, flag;
  logic [NCNT-1:0][5:0]     sel;
  logic [CW-1:0]            cyc;
  logic [NCNT-1:0][CW-1:0]  cnt;
  logic [PRE_LOG2-1:0]      pre_q;
  logic [5:0]               lvl_q, rise;
  logic [NCNT-1:0]          hit, wrap;
  logic                     wr_ctl, pc_clr, cc_clr, wr_cyc, cyc_tick, cyc_wrap;

  assign wr_ctl = reg_wr && reg_addr == 2'd0;
  assign wr_cyc = reg_wr && reg_addr == 2'd1;
  assign pc_clr = wr_ctl && reg_wdata[1];
  assign cc_clr = wr_ctl && reg_wdata[2];
  assign rise   = ev_level & ~lvl_q;

  function automatic logic ev_hit(input logic [5:0] code);
    logic [5:0] k;
    if (code <= 6'h07) return ev_pulse[code[2:0]];
    if (code <= 6'h13) begin
      k = (code - 6'h08) >> 1;
      return code[0] ? ev_level[k[2:0]] : rise[k[2:0]];
    end
    if (code <= 6'h19) begin
      k = code - 6'h0C;
      return ev_pulse[k[3:0]];
    end
    return 1'b0;
  endfunction

  always_comb begin
    for (int i = 0; i < NCNT; i++) begin
      hit[i]  = ev_hit(sel[i]);
      wrap[i] = hit[i] && (&cnt[i]) && !pc_clr && !(reg_wr && reg_addr == 2'(i + 2));
    end
  end

  assign cyc_tick = cc_en && (!cc_pre || (&pre_q));
  assign cyc_wrap = cyc_tick && (&cyc) && !cc_clr && !wr_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (pc_clr)                                  cnt[i] <= '0;
        else if (reg_wr && reg_addr == 2'(i + 2))    cnt[i] <= reg_wdata[CW-1:0];
        else if (hit[i])                             cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      pre_q <= '0;
    end else if (cc_clr) begin
      cyc   <= '0;
      pre_q <= '0;
    end else begin
      if (cc_en && cc_pre) pre_q <= pre_q + 1'b1;
      if (wr_cyc)          cyc   <= reg_wdata[CW-1:0];
      else if (cyc_tick)   cyc   <= cyc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_en  <= 1'b0;
      cc_pre <= 1'b0;
      ie     <= '0;
      sel    <= '0;
      flag   <= '0;
      lvl_q  <= '0;
    end else begin
      lvl_q <= ev_level;
      flag  <= (flag & ~(wr_ctl ? reg_wdata[10:8] : 3'b000)) | {cyc_wrap, wrap};
      if (wr_ctl) begin
        cc_en  <= reg_wdata[0];
        cc_pre <= reg_wdata[3];
        ie     <= reg_wdata[6:4];
        sel[0] <= reg_wdata[17:12];
        sel[1] <= reg_wdata[23:18];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {8'd0, sel[1], sel[0], 1'b0, flag, 1'b0, ie, cc_pre, 2'b00, cc_en};
      2'd1:    reg_rdata = 32'(cyc);
      2'd2:    reg_rdata = 32'(cnt[0]);
      default: reg_rdata = 32'(cnt[1]);
    endcase
  end

  assign irq = |(flag & ie);
endmodule

module evt_perf_counters_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic          cc_en,
  input logic [2:0]    flag,
  input logic [CW-1:0] cyc,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);
  p_pc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd0 && reg_wdata[1] |=> cnt0 == '0 && cnt1 == '0);

  p_cc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd0 && reg_wdata[2] |=> cyc == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_en && !reg_wr |=> $stable(cyc));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cc_en && !reg_wr |=> (cyc == $past(cyc) || cyc == $past(cyc) + 1'b1));

  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == '1 && !reg_wr) ##1 (cnt0 == '0) |-> flag[0]);

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd0 && reg_wdata[9] && cnt1 != '1 |=> !flag[1]);

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag == 3'b000 |-> !irq);
endmodule

bind evt_perf_counters evt_perf_counters_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .irq(irq), .cc_en(cc_en), .flag(flag),
  .cyc(cyc), .cnt0(cnt[0]), .cnt1(cnt[1])
);

// File: tb/evt_perf_counters_tb.sv
module evt_perf_counters_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [13:0] pulse = '0;
  logic [5:0]  level = '0;
  logic        irq;

  int    checks = 0;
  int    fails = 0;
  int    ncyc = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  evt_perf_counters u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .ev_pulse(pulse), .ev_level(level), .irq(irq)
  );

  bit [31:0] m_cyc, m_c0, m_c1;
  bit        m_en, m_pre;
  bit [2:0]  m_ie, m_flag;
  bit [5:0]  m_s0, m_s1, m_prev;
  int        m_presc;

  function automatic bit m_hit(bit [5:0] code);
    int c;
    if (code < 8) return pulse[code];
    if (code < 'h14) begin
      c = (int'(code) - 8) / 2;
      if (code % 2 == 1) return level[c];
      return level[c] && !m_prev[c];
    end
    if (code < 'h1A) return pulse[int'(code) - 'h14 + 8];
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_read(bit [1:0] a);
    case (a)
      0: return {8'd0, m_s1, m_s0, 1'b0, m_flag, 1'b0, m_ie, m_pre, 2'b00, m_en};
      1: return m_cyc;
      2: return m_c0;
      default: return m_c1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_c0 = 0; m_c1 = 0; m_en = 0; m_pre = 0;
      m_ie = 0; m_flag = 0; m_s0 = 0; m_s1 = 0; m_prev = 0; m_presc = 0;
    end else begin
      bit wc, h0, h1, tick;
      bit [2:0] nf;
      wc = wr && addr == 0;
      h0 = m_hit(m_s0);
      h1 = m_hit(m_s1);
      nf = m_flag;
      if (wc) nf = nf & ~wdata[10:8];
      if (wc && wdata[1]) begin
        m_c0 = 0; m_c1 = 0;
      end else begin
        if (wr && addr == 2) m_c0 = wdata;
        else if (h0) begin if (m_c0 == 32'hFFFF_FFFF) nf[0] = 1; m_c0 = m_c0 + 1; end
        if (wr && addr == 3) m_c1 = wdata;
        else if (h1) begin if (m_c1 == 32'hFFFF_FFFF) nf[1] = 1; m_c1 = m_c1 + 1; end
      end
      tick = m_en && (!m_pre || m_presc == 63);
      if (wc && wdata[2]) begin
        m_cyc = 0; m_presc = 0;
      end else begin
        if (m_en && m_pre) m_presc = (m_presc + 1) % 64;
        if (wr && addr == 1) m_cyc = wdata;
        else if (tick) begin if (m_cyc == 32'hFFFF_FFFF) nf[2] = 1; m_cyc = m_cyc + 1; end
      end
      m_flag = nf;
      if (wc) begin
        m_en = wdata[0]; m_pre = wdata[3]; m_ie = wdata[6:4];
        m_s0 = wdata[17:12]; m_s1 = wdata[23:18];
      end
      m_prev = level;
    end
  end

  task automatic compare();
    bit [31:0] exp;
    bit        eirq;
    exp  = m_read(addr);
    eirq = |(m_flag & m_ie);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", cur_req, addr, rdata, exp);
    end
    checks++;
    if (irq !== eirq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, eirq);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wr_reg(input bit [1:0] a, input bit [31:0] d);
    addr = a; wr = 1'b1; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic run(input int n, input bit [13:0] pm, input bit [5:0] lm);
    for (int i = 0; i < n; i++) begin
      addr  = addr + 2'd1;
      pulse = 14'($urandom) & pm;
      level = 6'($urandom) & lm;
      tick();
    end
    pulse = '0;
    level = '0;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1'b1;
    run(8, '0, '0);

    cur_req = "R12";
    wr_reg(0, 32'hFFFF_FFF9);
    run(4, '0, '0);
    wr_reg(0, 32'h0);
    run(4, '0, '0);

    cur_req = "R2";
    wr_reg(0, 32'h1);
    run(20, '0, '0);
    wr_reg(0, 32'h0);
    run(10, '0, '0);

    cur_req = "R3";
    wr_reg(0, 32'h9);
    run(200, '0, '0);

    cur_req = "R4";
    wr_reg(0, 32'hD);
    run(70, '0, '0);
    wr_reg(0, 32'h1);
    run(5, '0, '0);
    wr_reg(0, 32'h5);
    run(5, '0, '0);

    cur_req = "R5";
    for (int c = 0; c < 'h1A; c++) begin
      if (c < 8 || c >= 'h14) begin
        wr_reg(0, (c << 12) | (((c + 3) % 8) << 18));
        run(16, '1, '0);
      end
    end

    cur_req = "R6";
    for (int c = 8; c < 'h14; c++) begin
      wr_reg(0, (c << 12) | ((c ^ 1) << 18));
      run(30, '0, '1);
    end

    cur_req = "R7";
    for (int c = 'h1A; c < 64; c += 5) begin
      wr_reg(0, (c << 12) | ((63 - c + 'h1A) << 18));
      run(8, '1, '1);
    end

    cur_req = "R8";
    wr_reg(0, (7 << 12) | (9 << 18));
    run(10, '1, '1);
    wr_reg(0, 32'h2 | (7 << 12) | (9 << 18));
    run(4, '0, '0);

    cur_req = "R9";
    wr_reg(0, 32'h70 | (7 << 12) | (9 << 18));
    wr_reg(2, 32'hFFFF_FFFD);
    run(6, 14'h0080, '0);
    wr_reg(3, 32'hFFFF_FFFE);
    run(6, '0, 6'h01);
    wr_reg(1, 32'hFFFF_FFF0);
    wr_reg(0, 32'h71 | (7 << 12) | (9 << 18));
    run(24, '0, '0);

    cur_req = "R10";
    wr_reg(0, 32'h271 | (7 << 12) | (9 << 18));
    run(4, '0, '0);
    wr_reg(0, 32'h071 | (7 << 12) | (9 << 18));
    run(4, '0, '0);
    wr_reg(0, 32'h571 | (7 << 12) | (9 << 18));
    run(4, '0, '0);

    cur_req = "R11";
    wr_reg(2, 32'hFFFF_FFFF);
    wr_reg(0, 32'h20 | (7 << 12));
    run(3, 14'h0080, '0);
    wr_reg(0, 32'h10 | (7 << 12));
    run(3, '0, '0);
    wr_reg(0, 32'h110);
    run(3, '0, '0);

    cur_req = "R9";
    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 8 == 0) begin
        bit [31:0] d;
        bit [1:0]  a;
        a = 2'($urandom);
        d = $urandom;
        if (a != 0 && $urandom % 2 == 1) d = 32'hFFFF_FFF0 | (d & 32'hF);
        pulse = 14'($urandom);
        level = 6'($urandom);
        wr_reg(a, d);
      end else begin
        run(1, '1, '1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule